// File: doc/BRIEF.md
# Vector Floating-Point Unordered-or-Equal Signaling Compare

This unit compares two 128-bit vectors element by element and writes a mask. Each element is an IEEE 754 binary32 or binary64 value, chosen by a one-bit format select. An element of the result is all ones when its pair of operands is unordered or equal. Otherwise it is all zeros. Every result element has the same width as its source elements, so the output can go straight back into a vector register as an integer mask.

The compare is the signaling kind. Any NaN operand raises invalid-operation for its lane, whether the NaN is quiet or signaling, and that lane's default result is all ones. A flush-to-zero control treats subnormal inputs as zeros that keep their sign. Flushing never sets the inexact flag. The invalid flags of all lanes are combined into one sticky-free flag bit. When the matching enable bit is set, the unit raises a trap request and withholds the destination write-enable.

A valid input is accepted in one cycle. The result, the flags, the write-enable and the trap request appear on the registered outputs on the next clock edge.

Top module: `vfcmp_ueq_unit`

## Requirements
- R1: With `fmt_dbl`=0 the vectors hold four binary32 lanes, lane i at bits [32i+31:32i]. With `fmt_dbl`=1 they hold two binary64 lanes, lane i at bits [64i+63:64i]. Each lane is judged only on its own bits.
- R2: A result lane is all ones when its two operands are unordered or numerically equal, and all zeros otherwise. Lanes do not affect one another.
- R3: Positive zero equals negative zero. An infinity equals an infinity of the same sign. Opposite infinities are not equal.
- R4: A lane with any NaN operand, quiet or signaling, gives an all-ones result and sets the invalid flag, `flags` bit 4.
- R5: With `ftz_en`=1 a subnormal operand compares as a zero of its own sign. With `ftz_en`=0 it compares as its true value, so it differs from zero and from other subnormals.
- R6: Flushing never raises inexact. `flags` bits 3..0 (bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero) are always 0.
- R7: If any flag bit is set and the same bit of `exc_enable` is set, then `trap_req`=1 and `wr_en`=0. Otherwise an accepted operation gives `wr_en`=1 and `trap_req`=0.
- R8: The outputs of an operation accepted on a clock edge appear on the next edge, with `out_valid`=1. A cycle without `in_valid` gives `out_valid`, `wr_en` and `trap_req` all 0. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| fmt_dbl | input | 1 | 0: binary32 lanes, 1: binary64 lanes |
| ftz_en | input | 1 | Flush subnormal inputs to signed zero |
| exc_enable | input | 5 | Trap enables, same bit positions as `flags` |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Registered outputs hold a new result |
| result | output | 128 | Per-lane all-ones / all-zeros mask |
| flags | output | 5 | IEEE exception flags of the operation |
| wr_en | output | 1 | Destination write-enable |
| trap_req | output | 1 | Enabled exception raised, write suppressed |

## Verification
A fault in the classification or lane-select logic shows up in the very next result. It appears as a lane that is wrong as a whole, or as a 64-bit lane whose two halves disagree. The bench spots both on the first operation that uses the affected format, NaN kind or subnormal case. A fault in the flag or trap path shows up on the same edge as a write-enable that conflicts with the trap request, or as a flag with no NaN behind it. A fault in the output register shows up one cycle later, as `out_valid` or `wr_en` staying high in an idle cycle.

// File: rtl/vfcmp_pkg.sv
package vfcmp_pkg;
    localparam int VEC_W  = 128;
    localparam int SP_W   = 32;
    localparam int DP_W   = 64;
    localparam int FLAG_W = 5;

    localparam int FLG_INEXACT   = 0;
    localparam int FLG_UNDERFLOW = 1;
    localparam int FLG_OVERFLOW  = 2;
    localparam int FLG_DIVZERO   = 3;
    localparam int FLG_INVALID   = 4;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_DOUBLE = 1'b1
    } fmt_e;

    typedef struct packed {
        logic is_nan;
        logic is_zero;
    } fp_class_t;

    typedef struct packed {
        logic [VEC_W-1:0]  mask;
        logic [FLAG_W-1:0] flags;
        logic              wr_en;
        logic              trap;
    } cmp_result_t;

    function automatic logic [FLAG_W-1:0] build_flags(input logic invalid);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[FLG_INVALID] = invalid;
        return f;
    endfunction
endpackage

// File: rtl/vfcmp_classify.sv
module vfcmp_classify
    import vfcmp_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] op,
    input  logic          ftz,
    output fp_class_t     cls
);
    localparam int EXP_W = (EW == 64) ? 11 : 8;
    localparam int MAN_W = EW - EXP_W - 1;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    assign expo = op[EW-2 -: EXP_W];
    assign frac = op[MAN_W-1:0];

    always_comb begin
        cls.is_nan  = (&expo) && (|frac);
        cls.is_zero = (expo == '0) && ((frac == '0) || ftz);
    end
endmodule

// File: rtl/vfcmp_lane.sv
module vfcmp_lane
    import vfcmp_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic          ftz,
    output logic          hit,
    output logic          invalid
);
    fp_class_t ca, cb;

    vfcmp_classify #(.EW(EW)) u_cls_a (.op(a), .ftz(ftz), .cls(ca));
    vfcmp_classify #(.EW(EW)) u_cls_b (.op(b), .ftz(ftz), .cls(cb));

    logic unordered;
    logic equal;

    always_comb begin
        unordered = ca.is_nan | cb.is_nan;
        equal     = !unordered && ((ca.is_zero && cb.is_zero) || (a == b));
        invalid   = unordered;
        hit       = unordered | equal | invalid;
    end
endmodule

// File: rtl/vfcmp_lane_array.sv
module vfcmp_lane_array
    import vfcmp_pkg::*;
#(
    parameter int VW = 128,
    parameter int EW = 32
) (
    input  logic [VW-1:0]       a,
    input  logic [VW-1:0]       b,
    input  logic                ftz,
    output logic [VW-1:0]       mask,
    output logic [VW/EW-1:0]    invalid
);
    localparam int LANES = VW / EW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        vfcmp_lane #(.EW(EW)) u_lane (
            .a       (a[i*EW +: EW]),
            .b       (b[i*EW +: EW]),
            .ftz     (ftz),
            .hit     (hit),
            .invalid (invalid[i])
        );
        assign mask[i*EW +: EW] = {EW{hit}};
    end
endmodule

// File: rtl/vfcmp_outreg.sv
module vfcmp_outreg
    import vfcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  cmp_result_t d,
    output logic        q_valid,
    output cmp_result_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= valid;
            if (valid) begin
                q <= d;
            end else begin
                q.wr_en <= 1'b0;
                q.trap  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vfcmp_ueq_unit.sv
module vfcmp_ueq_unit
    import vfcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                fmt_dbl,
    input  logic                ftz_en,
    input  logic [FLAG_W-1:0]   exc_enable,
    input  logic [VEC_W-1:0]    src_a,
    input  logic [VEC_W-1:0]    src_b,
    output logic                out_valid,
    output logic [VEC_W-1:0]    result,
    output logic [FLAG_W-1:0]   flags,
    output logic                wr_en,
    output logic                trap_req
);
    localparam int SP_LANES = VEC_W / SP_W;
    localparam int DP_LANES = VEC_W / DP_W;

    logic [VEC_W-1:0]    sp_mask, dp_mask;
    logic [SP_LANES-1:0] sp_inv;
    logic [DP_LANES-1:0] dp_inv;

    vfcmp_lane_array #(.VW(VEC_W), .EW(SP_W)) u_sp (
        .a(src_a), .b(src_b), .ftz(ftz_en), .mask(sp_mask), .invalid(sp_inv)
    );
    vfcmp_lane_array #(.VW(VEC_W), .EW(DP_W)) u_dp (
        .a(src_a), .b(src_b), .ftz(ftz_en), .mask(dp_mask), .invalid(dp_inv)
    );

    fmt_e        fmt;
    cmp_result_t nxt, cur;
    logic        any_inv;
    logic        trap_hit;

    always_comb begin
        fmt      = fmt_e'(fmt_dbl);
        any_inv  = (fmt == FMT_DOUBLE) ? |dp_inv : |sp_inv;
        nxt.mask = (fmt == FMT_DOUBLE) ? dp_mask : sp_mask;
        nxt.flags = build_flags(any_inv);
        trap_hit  = |(nxt.flags & exc_enable);
        nxt.trap  = trap_hit;
        nxt.wr_en = !trap_hit;
    end

    vfcmp_outreg u_oreg (
        .clk(clk), .rst(rst), .valid(in_valid), .d(nxt),
        .q_valid(out_valid), .q(cur)
    );

    assign result   = cur.mask;
    assign flags    = cur.flags;
    assign wr_en    = cur.wr_en;
    assign trap_req = cur.trap;
endmodule

// File: rtl/vfcmp_ueq_chk.sv
module vfcmp_ueq_chk
    import vfcmp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                fmt_dbl,
    input logic                out_valid,
    input logic [VEC_W-1:0]    result,
    input logic [FLAG_W-1:0]   flags,
    input logic                wr_en,
    input logic                trap_req
);
    function automatic logic chunks_uniform(input logic [VEC_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < VEC_W / SP_W; i++) begin
            ok &= (v[i*SP_W +: SP_W] == '0) || (&v[i*SP_W +: SP_W]);
        end
        return ok;
    endfunction

    p_accept_lat_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !trap_req));
    p_wr_xor_trap_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (wr_en ^ trap_req));
    p_trap_cause_r7: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (|flags));
    p_only_invalid_r6: assert property (@(posedge clk) disable iff (rst)
        flags[FLG_DIVZERO:FLG_INEXACT] == '0);
    p_mask_uniform_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> chunks_uniform(result));
    p_dbl_halves_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_dbl) |=>
        (result[63:32] == result[31:0]) && (result[127:96] == result[95:64]));
    p_nan_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flags[FLG_INVALID]) |-> (result != '0));
endmodule

bind vfcmp_ueq_unit vfcmp_ueq_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
    .out_valid(out_valid), .result(result), .flags(flags),
    .wr_en(wr_en), .trap_req(trap_req)
);

// File: tb/vfcmp_ueq_unit_tb.sv
`timescale 1ns/1ps
module vfcmp_ueq_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         fmt_dbl;
    logic         ftz_en;
    logic [4:0]   exc_enable;
    logic [127:0] src_a, src_b;
    logic         out_valid;
    logic [127:0] result;
    logic [4:0]   flags;
    logic         wr_en;
    logic         trap_req;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] O32 = 32'hFFFF_FFFF, Z32 = 32'h0;
    localparam logic [63:0] O64 = 64'hFFFF_FFFF_FFFF_FFFF, Z64 = 64'h0;
    localparam logic [31:0] S_ONE = 32'h3F80_0000, S_TWO = 32'h4000_0000, S_MONE = 32'hBF80_0000;
    localparam logic [31:0] S_PZ = 32'h0000_0000, S_NZ = 32'h8000_0000;
    localparam logic [31:0] S_PINF = 32'h7F80_0000, S_NINF = 32'hFF80_0000;
    localparam logic [31:0] S_QNAN = 32'h7FC0_0000, S_SNAN = 32'h7F80_0001;
    localparam logic [31:0] S_SUB = 32'h0000_0001, S_NSUB = 32'h8000_0001, S_SUB2 = 32'h0000_0002;
    localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_ONEP = 64'h3FF0_0000_0000_0001;
    localparam logic [63:0] D_PZ = 64'h0, D_NZ = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000, D_NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000, D_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_SUB = 64'h0000_0000_0000_0001;

    vfcmp_ueq_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .ftz_en(ftz_en), .exc_enable(exc_enable), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .flags(flags),
        .wr_en(wr_en), .trap_req(trap_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [127:0] a, input logic [127:0] b,
                         input logic dbl, input logic ftz, input logic [4:0] en);
        @(negedge clk);
        src_a = a; src_b = b; fmt_dbl = dbl; ftz_en = ftz; exc_enable = en;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [127:0] res,
                              input logic [4:0] flg, input logic wr, input logic tr);
        chk(req, "out_valid", 128'(out_valid), 128'(1'b1));
        chk(req, "result",    result, res);
        chk(req, "flags",     128'(flags), 128'(flg));
        chk(req, "wr_en",     128'(wr_en), 128'(wr));
        chk(req, "trap_req",  128'(trap_req), 128'(tr));
    endtask

    task automatic t_reset();
        chk("R8", "reset out_valid", 128'(out_valid), 128'(0));
        chk("R8", "reset result", result, 128'(0));
        chk("R8", "reset flags", 128'(flags), 128'(0));
        chk("R8", "reset wr/trap", 128'({wr_en, trap_req}), 128'(0));
    endtask

    task automatic t_single_basic();
        issue({S_ONE, S_ONE, S_TWO, S_NINF}, {S_ONE, S_TWO, S_TWO, S_PINF}, 1'b0, 1'b0, 5'b0);
        expect_out("R2", {O32, Z32, O32, Z32}, 5'b0, 1'b1, 1'b0);
    endtask

    task automatic t_zeros_inf();
        issue({S_PZ, S_PINF, S_NINF, S_ONE}, {S_NZ, S_PINF, S_NINF, S_MONE}, 1'b0, 1'b0, 5'b0);
        expect_out("R3", {O32, O32, O32, Z32}, 5'b0, 1'b1, 1'b0);
    endtask

    task automatic t_nan_single();
        issue({S_QNAN, S_ONE, S_ONE, S_TWO}, {S_ONE, S_SNAN, S_ONE, S_ONE}, 1'b0, 1'b0, 5'b0);
        expect_out("R4", {O32, O32, O32, Z32}, 5'b10000, 1'b1, 1'b0);
        issue({S_ONE, S_ONE, S_QNAN, S_ONE}, {S_ONE, S_ONE, S_QNAN, S_TWO}, 1'b0, 1'b0, 5'b0);
        expect_out("R4", {O32, O32, O32, Z32}, 5'b10000, 1'b1, 1'b0);
    endtask

    task automatic t_trap();
        issue({S_SNAN, S_ONE, S_ONE, S_ONE}, {S_ONE, S_ONE, S_ONE, S_TWO}, 1'b0, 1'b0, 5'b10000);
        expect_out("R7", {O32, O32, O32, Z32}, 5'b10000, 1'b0, 1'b1);
        issue({S_SNAN, S_ONE, S_ONE, S_ONE}, {S_ONE, S_ONE, S_ONE, S_TWO}, 1'b0, 1'b0, 5'b01111);
        expect_out("R7", {O32, O32, O32, Z32}, 5'b10000, 1'b1, 1'b0);
        issue({S_ONE, S_ONE, S_ONE, S_ONE}, {S_ONE, S_ONE, S_ONE, S_ONE}, 1'b0, 1'b0, 5'b11111);
        expect_out("R7", {O32, O32, O32, O32}, 5'b0, 1'b1, 1'b0);
    endtask

    task automatic t_ftz_single();
        issue({S_SUB, S_NSUB, S_SUB, S_SUB}, {S_SUB, S_PZ, S_SUB2, S_NZ}, 1'b0, 1'b1, 5'b00001);
        expect_out("R5", {O32, O32, O32, O32}, 5'b0, 1'b1, 1'b0);
        chk("R6", "no inexact on flush", 128'(flags[0]), 128'(0));
        issue({S_SUB, S_NSUB, S_SUB, S_SUB}, {S_SUB, S_PZ, S_SUB2, S_NZ}, 1'b0, 1'b0, 5'b00001);
        expect_out("R5", {O32, Z32, Z32, Z32}, 5'b0, 1'b1, 1'b0);
    endtask

    task automatic t_double();
        issue({D_ONE, D_NZ}, {D_ONE, D_PZ}, 1'b1, 1'b0, 5'b0);
        expect_out("R1", {O64, O64}, 5'b0, 1'b1, 1'b0);
        issue({D_PINF, D_SNAN}, {D_NINF, D_ONE}, 1'b1, 1'b0, 5'b0);
        expect_out("R4", {Z64, O64}, 5'b10000, 1'b1, 1'b0);
        issue({D_QNAN, D_PINF}, {D_QNAN, D_PINF}, 1'b1, 1'b0, 5'b10000);
        expect_out("R7", {O64, O64}, 5'b10000, 1'b0, 1'b1);
    endtask

    task automatic t_format_split();
        issue({D_ONE, D_ONEP}, {D_ONE, D_ONE}, 1'b1, 1'b0, 5'b0);
        expect_out("R1", {O64, Z64}, 5'b0, 1'b1, 1'b0);
        issue({D_ONE, D_ONEP}, {D_ONE, D_ONE}, 1'b0, 1'b0, 5'b0);
        expect_out("R1", {O32, O32, O32, Z32}, 5'b0, 1'b1, 1'b0);
    endtask

    task automatic t_ftz_double();
        issue({D_SUB, D_SUB}, {D_NZ, D_SUB}, 1'b1, 1'b1, 5'b00001);
        expect_out("R5", {O64, O64}, 5'b0, 1'b1, 1'b0);
        issue({D_SUB, D_SUB}, {D_NZ, D_SUB}, 1'b1, 1'b0, 5'b00001);
        expect_out("R5", {Z64, O64}, 5'b0, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        issue({S_SNAN, S_ONE, S_ONE, S_ONE}, {S_ONE, S_ONE, S_ONE, S_ONE}, 1'b0, 1'b0, 5'b10000);
        @(negedge clk);
        chk("R8", "idle out_valid", 128'(out_valid), 128'(0));
        chk("R8", "idle wr_en", 128'(wr_en), 128'(0));
        chk("R8", "idle trap_req", 128'(trap_req), 128'(0));
    endtask

    initial begin
        #2ms;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; fmt_dbl = 1'b0; ftz_en = 1'b0;
        exc_enable = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_basic();
        t_zeros_inf();
        t_nan_single();
        t_trap();
        t_ftz_single();
        t_double();
        t_format_split();
        t_ftz_double();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule